// File: doc/BRIEF.md
# LIN Header Break and Sync Receiver

This block listens to the receive line of a LIN slave and deals only with the start of each frame header. While it is enabled and idle, it waits for any level change on the line. That wake-up edge puts it into break-hunting mode. In that mode the block samples the line once per nominal bit, at the middle of the bit, and counts how long the line stays low. When the line returns high, the block judges the low run. A run long enough to be a break raises a completion pulse. A run that is too short raises an error pulse, and the block goes straight back to hunting without any further action.

After a valid break the block measures the sync byte, 0x55, that follows. It stamps each falling edge of that byte with a free-running system-clock counter. It also shifts in the sampled data bits. When the last data bit has been sampled, it reports the average bit period, in clock cycles, as the span from the first edge to the last edge divided by eight. The results then stay frozen, and the block ignores the line until software re-arms it. This matches the point in a frame where the identifier, data and checksum have been handled elsewhere.

Top module: `lin_hdr_rx`

## Requirements
- R1: While `en_i` is low, the block stays idle: `brk_mode_o` and `sync_valid_o` read 0, and line activity produces no pulse.
- R2: With `en_i` high and the block idle, any edge on the synchronized line puts it into break-hunting mode (`brk_mode_o` = 1).
- R3: In break-hunting mode, a low run of at least 11 mid-bit samples that ends with a high sample gives exactly one single-cycle `brk_done_o` pulse, and the block leaves break-hunting mode.
- R4: A low run of 1 to 10 samples that ends with a high sample gives a single-cycle `brk_err_o` pulse and no `brk_done_o`, and the block stays in break-hunting mode.
- R5: Once the block has spent a cycle in break-hunting mode, `sync_byte_o` reads 0xFF, the shift register's reset value. No byte is assembled during the break.
- R6: A 13-bit low break, the usual length sent by a master, is accepted as valid.
- R7: In the sync phase, the counter value at each of the five falling edges is held in slot k of `cap_ts_o` (bits 16k+15 down to 16k, with k = 0 for the start-bit edge). Consecutive slots therefore differ by two bit periods.
- R8: When the eighth data bit of the sync byte has been sampled, `sync_valid_o` rises. `sync_width_o` then equals (slot4 - slot0) mod 2^16 shifted right by 3, and `sync_byte_o` holds the data bits sampled LSB-first (0x55 for a correct sync byte).
- R9: `wrap_o` is set when the capture counter passes from 0xFFFF to 0 between the first and the last edge capture. The width is still correct in that case.
- R10: After completion, line activity changes neither the results nor the pulse outputs. A `rearm_i` pulse returns the block to break-hunting mode and clears `sync_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable |
| rearm_i | input | 1 | Return to break-hunting mode |
| line_i | input | 1 | Asynchronous LIN receive line, idle high |
| tick_i | input | 1 | One-cycle strobe at the middle of each nominal bit |
| brk_done_o | output | 1 | Valid-break pulse |
| brk_err_o | output | 1 | Short-break pulse |
| brk_mode_o | output | 1 | Break-hunting mode active |
| sync_valid_o | output | 1 | Sync measurement complete and held |
| sync_width_o | output | 16 | Average sync bit period in clock cycles |
| sync_byte_o | output | 8 | Shift register contents |
| cap_ts_o | output | 80 | Five edge timestamps, slot 0 in the low bits |
| wrap_o | output | 1 | Counter wrapped during the measurement |

## Verification
The assertions assume that `tick_i` is a one-cycle strobe, spaced a whole nominal bit apart. They also assume that the line changes only near bit boundaries, so every sample sees a settled level. The bench meets both by deriving each tick from its own bit-time counter, half a bit after it drives the line level. It uses an even number of clock cycles per bit, and a falling edge never lies closer than half a bit to a tick. The timestamp checks compare only differences between slots, so the bench never has to know the absolute counter value.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BREAK = 2'd1,
    ST_SYNC  = 2'd2,
    ST_HOLD  = 2'd3
  } hdr_state_t;
endpackage

// File: rtl/lin_line_sync.sv
// Brings the asynchronous line into the clock domain and flags its edges.
module lin_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_s_o,
  output logic edge_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], line_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign line_s_o = sh_q[STAGES-1];
  assign edge_o   = line_s_o ^ prev_q;
  assign fall_o   = prev_q & ~line_s_o;
endmodule

// File: rtl/lin_brk_det.sv
// Counts low mid-bit samples and judges the run when the line returns high.
module lin_brk_det #(
  parameter int MIN_LOW = 11,
  parameter int RUN_W   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic tick_i,
  input  logic sample_i,
  output logic ok_o,
  output logic err_o
);
  localparam logic [RUN_W-1:0] THRESH = RUN_W'(MIN_LOW);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      run_q <= '0;
      ok_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      ok_o  <= 1'b0;
      err_o <= 1'b0;
      if (tick_i) begin
        if (!sample_i) begin
          if (run_q != '1) run_q <= run_q + 1'b1;
        end else if (run_q != '0) begin
          if (run_q >= THRESH) ok_o <= 1'b1;
          else                 err_o <= 1'b1;
          run_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/lin_sync_cap.sv
// Free-running capture counter, edge timestamps and data shift of the sync byte.
module lin_sync_cap #(
  parameter int CW    = 16,
  parameter int NEDGE = 5,
  parameter int DBITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                active_i,
  input  logic                tick_i,
  input  logic                sample_i,
  input  logic                fall_i,
  output logic [NEDGE*CW-1:0] cap_flat_o,
  output logic [CW-1:0]       width_o,
  output logic [DBITS-1:0]    byte_o,
  output logic                wrap_o,
  output logic                done_o
);
  localparam int IW    = $clog2(NEDGE + 1);
  localparam int BW    = $clog2(DBITS + 1);
  localparam int SHIFT = $clog2(DBITS);

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cap_q [NEDGE];
  logic [IW-1:0]    idx_q;
  logic [BW-1:0]    bits_q;
  logic             started_q;
  logic [DBITS-1:0] shreg_q;
  logic [CW-1:0]    span;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NEDGE; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        cap_q[k] <= '0;
      else if (!clr_i && active_i && fall_i && idx_q == IW'(k))
        cap_q[k] <= cnt_q;
    end
    assign cap_flat_o[k*CW +: CW] = cap_q[k];
  end

  assign span = cap_q[NEDGE-1] - cap_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      bits_q    <= '0;
      started_q <= 1'b0;
      shreg_q   <= '1;
      wrap_o    <= 1'b0;
      width_o   <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        idx_q     <= '0;
        bits_q    <= '0;
        started_q <= 1'b0;
        shreg_q   <= '1;
        wrap_o    <= 1'b0;
      end else if (active_i) begin
        if (fall_i && idx_q < IW'(NEDGE)) idx_q <= idx_q + 1'b1;
        if (cnt_q == '1 && idx_q != '0 && idx_q < IW'(NEDGE)) wrap_o <= 1'b1;
        if (tick_i) begin
          if (!started_q) begin
            if (!sample_i) started_q <= 1'b1;
          end else if (bits_q < BW'(DBITS)) begin
            shreg_q <= {sample_i, shreg_q[DBITS-1:1]};
            bits_q  <= bits_q + 1'b1;
            if (bits_q == BW'(DBITS - 1)) begin
              done_o  <= 1'b1;
              width_o <= span >> SHIFT;
            end
          end
        end
      end
    end
  end

  assign byte_o = shreg_q;
endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx #(
  parameter int CW      = 16,
  parameter int NEDGE   = 5,
  parameter int DBITS   = 8,
  parameter int MIN_LOW = 11,
  parameter int RUN_W   = 5,
  parameter int SYNC_FF = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic                rearm_i,
  input  logic                line_i,
  input  logic                tick_i,
  output logic                brk_done_o,
  output logic                brk_err_o,
  output logic                brk_mode_o,
  output logic                sync_valid_o,
  output logic [CW-1:0]       sync_width_o,
  output logic [DBITS-1:0]    sync_byte_o,
  output logic [NEDGE*CW-1:0] cap_ts_o,
  output logic                wrap_o
);
  import lin_hdr_pkg::*;

  hdr_state_t state_q, state_d;
  logic line_s, edge_s, fall_s;
  logic brk_ok, brk_err, cap_done;

  lin_line_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst(rst), .line_i(line_i),
    .line_s_o(line_s), .edge_o(edge_s), .fall_o(fall_s)
  );

  lin_brk_det #(.MIN_LOW(MIN_LOW), .RUN_W(RUN_W)) u_brk (
    .clk(clk), .rst(rst), .active_i(state_q == ST_BREAK),
    .tick_i(tick_i), .sample_i(line_s), .ok_o(brk_ok), .err_o(brk_err)
  );

  lin_sync_cap #(.CW(CW), .NEDGE(NEDGE), .DBITS(DBITS)) u_cap (
    .clk(clk), .rst(rst),
    .clr_i(state_q == ST_BREAK || state_q == ST_IDLE),
    .active_i(state_q == ST_SYNC), .tick_i(tick_i), .sample_i(line_s),
    .fall_i(fall_s), .cap_flat_o(cap_ts_o), .width_o(sync_width_o),
    .byte_o(sync_byte_o), .wrap_o(wrap_o), .done_o(cap_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (rearm_i || edge_s) state_d = ST_BREAK;
      ST_BREAK: if (brk_ok)            state_d = ST_SYNC;
      ST_SYNC:  if (rearm_i)           state_d = ST_BREAK;
                else if (cap_done)     state_d = ST_HOLD;
      ST_HOLD:  if (rearm_i)           state_d = ST_BREAK;
      default:                         state_d = ST_IDLE;
    endcase
    if (!en_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign brk_done_o   = brk_ok;
  assign brk_err_o    = brk_err;
  assign brk_mode_o   = (state_q == ST_BREAK);
  assign sync_valid_o = (state_q == ST_HOLD);
endmodule

// File: rtl/lin_hdr_rx_chk.sv
module lin_hdr_rx_chk #(
  parameter int CW    = 16,
  parameter int DBITS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             rearm_i,
  input logic             brk_done_o,
  input logic             brk_err_o,
  input logic             brk_mode_o,
  input logic             sync_valid_o,
  input logic [CW-1:0]    sync_width_o,
  input logic [DBITS-1:0] sync_byte_o
);
  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!brk_mode_o && !sync_valid_o));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    brk_done_o |=> (!brk_done_o && !brk_mode_o));

  a_r4_err_stays: assert property (@(posedge clk) disable iff (rst)
    brk_err_o |-> (brk_mode_o && !brk_done_o));

  a_r4_err_single: assert property (@(posedge clk) disable iff (rst)
    brk_err_o |=> !brk_err_o);

  a_r5_shreg_ff: assert property (@(posedge clk) disable iff (rst)
    brk_mode_o |=> (!brk_mode_o || sync_byte_o == '1));

  a_r10_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (sync_valid_o && en_i && !rearm_i) |=> (sync_valid_o && $stable(sync_width_o)));
endmodule

bind lin_hdr_rx lin_hdr_rx_chk #(.CW(CW), .DBITS(DBITS)) chk_i (
  .clk(clk), .rst(rst), .en_i(en_i), .rearm_i(rearm_i),
  .brk_done_o(brk_done_o), .brk_err_o(brk_err_o), .brk_mode_o(brk_mode_o),
  .sync_valid_o(sync_valid_o), .sync_width_o(sync_width_o),
  .sync_byte_o(sync_byte_o)
);

// File: tb/lin_hdr_rx_tb_top.sv
module lin_hdr_rx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, rearm_i = 1'b0, line_i = 1'b1, tick_i = 1'b0;
  logic brk_done_o, brk_err_o, brk_mode_o, sync_valid_o, wrap_o;
  logic [15:0] sync_width_o;
  logic [7:0]  sync_byte_o;
  logic [79:0] cap_ts_o;

  int checks = 0, errors = 0;
  int done_seen = 0, err_seen = 0, exp_done = 0, exp_err = 0;
  int unsigned cyc = 0;
  bit finished = 1'b0;
  logic prev_done = 1'b0, prev_err = 1'b0;

  always #5 clk = ~clk;

  lin_hdr_rx dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .rearm_i(rearm_i), .line_i(line_i),
    .tick_i(tick_i), .brk_done_o(brk_done_o), .brk_err_o(brk_err_o),
    .brk_mode_o(brk_mode_o), .sync_valid_o(sync_valid_o),
    .sync_width_o(sync_width_o), .sync_byte_o(sync_byte_o),
    .cap_ts_o(cap_ts_o), .wrap_o(wrap_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock monitor: counts pulses, and a pulse must never last two cycles.
  always @(negedge clk) begin
    if (rst) begin
      prev_done <= 1'b0;
      prev_err  <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (brk_done_o) done_seen++;
      if (brk_err_o)  err_seen++;
      if (brk_done_o && prev_done) check("R3 done pulse width", 2, 1);
      if (brk_err_o && prev_err)   check("R4 err pulse width", 2, 1);
      prev_done <= brk_done_o;
      prev_err  <= brk_err_o;
    end
  end

  task automatic send_bit(input logic v, input int bt);
    line_i = v;
    repeat (bt / 2) @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (bt - bt / 2 - 1) @(negedge clk);
  endtask

  task automatic send_run(input logic v, input int n, input int bt);
    for (int i = 0; i < n; i++) send_bit(v, bt);
  endtask

  task automatic send_byte(input logic [7:0] b, input int bt);
    send_bit(1'b0, bt);
    for (int i = 0; i < 8; i++) send_bit(b[i], bt);
    send_bit(1'b1, bt);
  endtask

  function automatic longint slot(input int k);
    return longint'(cap_ts_o[k*16 +: 16]);
  endfunction

  task automatic check_sync(input string tag, input int bt, input logic exp_wrap);
    check({tag, " R8 sync_valid"}, sync_valid_o, 1);
    check({tag, " R8 width"}, sync_width_o, bt);
    check({tag, " R8 byte"}, sync_byte_o, 8'h55);
    for (int k = 1; k < 5; k++)
      check({tag, " R7 slot spacing"}, (slot(k) - slot(k - 1)) & 16'hFFFF, 2 * bt);
    check({tag, " R9 wrap"}, wrap_o, exp_wrap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset brk_mode", brk_mode_o, 0);
    check("reset sync_valid", sync_valid_o, 0);
    check("reset byte", sync_byte_o, 8'hFF);
    check("reset pulses", brk_done_o | brk_err_o, 0);

    // R1: disabled, a full break must not wake the block
    send_run(1'b0, 14, 40);
    send_run(1'b1, 3, 40);
    check("R1 no wake while disabled", brk_mode_o, 0);
    check("R1 no pulses", done_seen + err_seen, 0);

    // R2 and R4: a short wake-up pulse enters break mode and reads as a short break
    en_i = 1'b1;
    send_run(1'b1, 2, 40);
    check("R2 still idle before edge", brk_mode_o, 0);
    send_run(1'b0, 2, 40);
    check("R2 edge entered break mode", brk_mode_o, 1);
    send_run(1'b1, 3, 40);
    exp_err++;
    check("R4 err count after wake pulse", err_seen, exp_err);
    check("R5 byte FF in break", sync_byte_o, 8'hFF);

    // R4 boundary: 10 low bits is short
    send_run(1'b0, 10, 40);
    send_run(1'b1, 2, 40);
    exp_err++;
    check("R4 err count 10 bits", err_seen, exp_err);
    check("R4 no done 10 bits", done_seen, exp_done);
    check("R4 stays in break", brk_mode_o, 1);

    // R3 boundary: 11 low bits then sync byte at 40 cycles per bit
    send_run(1'b0, 11, 40);
    send_bit(1'b1, 40);
    exp_done++;
    check("R3 done after 11 bits", done_seen, exp_done);
    check("R3 left break mode", brk_mode_o, 0);
    send_byte(8'h55, 40);
    send_run(1'b1, 2, 40);
    check_sync("run1", 40, 1'b0);

    // R10: activity while holding is ignored
    send_run(1'b0, 13, 40);
    send_run(1'b1, 2, 40);
    check("R10 no pulse while holding", done_seen + err_seen, exp_done + exp_err);
    check("R10 width kept", sync_width_o, 40);
    check("R10 still valid", sync_valid_o, 1);

    // R10 re-arm, then R6: 13-bit break, 48 cycles per bit
    rearm_i = 1'b1;
    @(negedge clk);
    rearm_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 rearm break mode", brk_mode_o, 1);
    check("R10 rearm clears valid", sync_valid_o, 0);
    check("R5 byte FF after rearm", sync_byte_o, 8'hFF);
    send_run(1'b0, 13, 48);
    send_bit(1'b1, 48);
    exp_done++;
    check("R6 13-bit break accepted", done_seen, exp_done);
    send_byte(8'h55, 48);
    send_run(1'b1, 2, 48);
    check_sync("run2", 48, 1'b0);

    // R9: place the sync field across the counter wrap
    rearm_i = 1'b1;
    @(negedge clk);
    rearm_i = 1'b0;
    while (cyc < 64836) @(negedge clk);
    send_run(1'b0, 13, 40);
    send_bit(1'b1, 40);
    exp_done++;
    send_byte(8'h55, 40);
    send_run(1'b1, 2, 40);
    check("R3 done count run3", done_seen, exp_done);
    check_sync("run3", 40, 1'b1);
    check("R4 final err count", err_seen, exp_err);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule